// File: doc/BRIEF.md
# Baugh-Wooley Signed Array Multiplier

This block multiplies two N-bit two's-complement operands and returns the full 2N-bit two's-complement product. Sign handling needs no sign extension. Selected partial-product bits are complemented and two constant ones are injected, so every bit in the array carries positive weight. The rows of that array are then reduced level by level. Each group of five rows goes through a row of 5:3 counters, each group of three goes through a row of full adders, and any leftover rows pass straight through. This continues until two rows remain. A single carry-propagate addition then gives the product. For N=5 there are six rows (five partial products plus one row of constants), and they shrink 6, 4, 3, 2 over three reduction levels.

Operands enter on a valid/ready stream and the product leaves on a second valid/ready stream. The parameter `REG_OUT` selects between two output modes:

- With `REG_OUT=1`, a single output register holds one product. A new pair is accepted when that register is empty or is being drained in the same cycle. While the consumer holds `out_ready` low, the held product and `out_valid` stay frozen, and back-pressure reaches the producer through `in_ready`.
- With `REG_OUT=0`, the block is purely combinational. Valid and ready pass straight through.

Top module: `bw_mult`

## Requirements
- R1: For every operand pair, `prod` equals the signed product of `a` and `b` as a 2N-bit two's-complement value.
- R2: With both operands at the most negative value (bit pattern 1 followed by N-1 zeros), `prod` is +2^(2N-2).
- R3: With `REG_OUT=1`, a pair accepted at a clock edge (`in_valid` and `in_ready` both high) shows its product on `prod` with `out_valid` high from that edge onward.
- R4: With `REG_OUT=1`, while `out_valid` is high and `out_ready` is low, `out_valid` stays high and `prod` keeps its value on the next cycle.
- R5: With `REG_OUT=1`, `in_ready` is high exactly when `out_valid` is low or `out_ready` is high.
- R6: With `REG_OUT=0`, `out_valid` equals `in_valid`, `in_ready` equals `out_ready`, and `prod` is the product of the current operands in the same cycle.
- R7: After reset (`rst_n` low, active-low, asynchronous) `out_valid` is low and `in_ready` is high.
- R8: An operand of -1 (all ones) yields the two's-complement negation of the other operand, including the most negative value times -1, which gives +2^(N-1).
- R9: An operand of zero yields a product of zero, whatever the other operand is.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand pair on `a`/`b` is valid |
| in_ready | output | 1 | Block accepts the operand pair this cycle |
| a | input | N | Multiplicand, two's complement |
| b | input | N | Multiplier, two's complement |
| out_valid | output | 1 | `prod` holds a valid product |
| out_ready | input | 1 | Consumer takes the product this cycle |
| prod | output | 2N | Signed product, two's complement |

## Verification
In registered mode, a product is due one clock edge after its pair is accepted. The scoreboard stores the expected value at the moment of acceptance and compares it at the first sampling point where `out_valid` and `out_ready` are both high. A separate check confirms that `out_valid` is already high one cycle after acceptance. In pass-through mode the product is due in the same cycle, so pushes are sampled slightly earlier in the cycle than pops. All sampling happens between clock edges, after the inputs driven at the falling edge have settled.

// File: rtl/bw_mult_pkg.sv
package bw_mult_pkg;

  // rows left after one reduction level: each 5 -> 3, a 3 or 4 tail -> 2 or 3
  function automatic int rows_after(input int r);
    int q;
    int m;
    q = r / 5;
    m = r % 5;
    return 3 * q + ((m >= 3) ? (m - 1) : m);
  endfunction

  function automatic int rows_at(input int n, input int lvl);
    int r;
    r = n + 1;
    for (int k = 0; k < lvl; k++) r = rows_after(r);
    return r;
  endfunction

  function automatic int stage_count(input int n);
    int r;
    int s;
    r = n + 1;
    s = 0;
    while (r > 2) begin
      r = rows_after(r);
      s++;
    end
    return s;
  endfunction

  // one bit of the population count of five equal-weight bits
  function automatic logic pick5(input logic [4:0] v, input int idx);
    logic [2:0] c;
    c = 3'(v[0]) + 3'(v[1]) + 3'(v[2]) + 3'(v[3]) + 3'(v[4]);
    return c[idx];
  endfunction

  function automatic logic maj3(input logic x, input logic y, input logic z);
    return (x & y) | (x & z) | (y & z);
  endfunction

endpackage

// File: rtl/bw_pp_gen.sv
module bw_pp_gen #(
  parameter int N = 8,
  localparam int W = 2 * N
) (
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  output logic [W-1:0] rows [0:N]
);
  always_comb begin
    for (int i = 0; i < N; i++) begin
      rows[i] = '0;
      for (int j = 0; j < N; j++) begin
        // complement the row MSB in rows 0..N-2, and all but the MSB in the last row
        rows[i][i+j] = (a[j] & b[i]) ^ ((j == N - 1) != (i == N - 1));
      end
    end
    rows[N] = '0;
    rows[N][N] = 1'b1;
    rows[N][W-1] = 1'b1;
  end
endmodule

// File: rtl/csa53_row.sv
module csa53_row #(
  parameter int W = 16
) (
  input  logic [W-1:0] x0,
  input  logic [W-1:0] x1,
  input  logic [W-1:0] x2,
  input  logic [W-1:0] x3,
  input  logic [W-1:0] x4,
  output logic [W-1:0] s0,
  output logic [W-1:0] s1,
  output logic [W-1:0] s2
);
  import bw_mult_pkg::*;

  for (genvar k = 0; k < W; k++) begin : g_bit
    assign s0[k] = pick5({x4[k], x3[k], x2[k], x1[k], x0[k]}, 0);
    if (k >= 1) begin : g_w2
      assign s1[k] = pick5({x4[k-1], x3[k-1], x2[k-1], x1[k-1], x0[k-1]}, 1);
    end else begin : g_w2z
      assign s1[k] = 1'b0;
    end
    if (k >= 2) begin : g_w4
      assign s2[k] = pick5({x4[k-2], x3[k-2], x2[k-2], x1[k-2], x0[k-2]}, 2);
    end else begin : g_w4z
      assign s2[k] = 1'b0;
    end
  end
endmodule

// File: rtl/csa32_row.sv
module csa32_row #(
  parameter int W = 16
) (
  input  logic [W-1:0] x0,
  input  logic [W-1:0] x1,
  input  logic [W-1:0] x2,
  output logic [W-1:0] s,
  output logic [W-1:0] c
);
  import bw_mult_pkg::*;

  assign s = x0 ^ x1 ^ x2;
  for (genvar k = 0; k < W; k++) begin : g_bit
    if (k >= 1) begin : g_cy
      assign c[k] = maj3(x0[k-1], x1[k-1], x2[k-1]);
    end else begin : g_cz
      assign c[k] = 1'b0;
    end
  end
endmodule

// File: rtl/bw_mult.sv
module bw_mult #(
  parameter int N = 8,
  parameter bit REG_OUT = 1'b1,
  localparam int W = 2 * N
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] prod
);
  import bw_mult_pkg::*;

  localparam int MAXR = N + 1;
  localparam int STG  = stage_count(N);

  logic [W-1:0] pp_rows [0:N];
  logic [W-1:0] lvl [0:STG][0:MAXR-1];
  logic [W-1:0] sum_w;

  bw_pp_gen #(.N(N)) u_pp (.a(a), .b(b), .rows(pp_rows));

  for (genvar r = 0; r < MAXR; r++) begin : g_l0
    assign lvl[0][r] = pp_rows[r];
  end

  for (genvar s = 0; s < STG; s++) begin : g_stage
    localparam int RI = rows_at(N, s);
    localparam int RO = rows_at(N, s + 1);
    localparam int Q  = RI / 5;
    localparam int M  = RI % 5;

    for (genvar g = 0; g < Q; g++) begin : g_c53
      csa53_row #(.W(W)) u_c53 (
        .x0(lvl[s][5*g]),   .x1(lvl[s][5*g+1]), .x2(lvl[s][5*g+2]),
        .x3(lvl[s][5*g+3]), .x4(lvl[s][5*g+4]),
        .s0(lvl[s+1][3*g]), .s1(lvl[s+1][3*g+1]), .s2(lvl[s+1][3*g+2])
      );
    end

    if (M >= 3) begin : g_tail_fa
      csa32_row #(.W(W)) u_c32 (
        .x0(lvl[s][5*Q]), .x1(lvl[s][5*Q+1]), .x2(lvl[s][5*Q+2]),
        .s(lvl[s+1][3*Q]), .c(lvl[s+1][3*Q+1])
      );
      if (M == 4) begin : g_pass4
        assign lvl[s+1][3*Q+2] = lvl[s][5*Q+3];
      end
    end else begin : g_tail_pass
      for (genvar t = 0; t < M; t++) begin : g_pass
        assign lvl[s+1][3*Q+t] = lvl[s][5*Q+t];
      end
    end

    for (genvar r = RO; r < MAXR; r++) begin : g_zero
      assign lvl[s+1][r] = '0;
    end
  end

  // final carry-propagate addition, truncated to 2N bits
  assign sum_w = lvl[STG][0] + lvl[STG][1];

  if (REG_OUT) begin : g_reg
    logic         vld_q;
    logic [W-1:0] prod_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q  <= 1'b0;
        prod_q <= '0;
      end else if (in_valid && in_ready) begin
        vld_q  <= 1'b1;
        prod_q <= sum_w;
      end else if (out_ready) begin
        vld_q  <= 1'b0;
      end
    end

    assign in_ready  = !vld_q || out_ready;
    assign out_valid = vld_q;
    assign prod      = prod_q;
  end else begin : g_comb
    assign in_ready  = out_ready;
    assign out_valid = in_valid;
    assign prod      = sum_w;
  end
endmodule

// File: rtl/bw_mult_chk.sv
module bw_mult_chk #(
  parameter int N = 8,
  parameter bit REG_OUT = 1'b1,
  localparam int W = 2 * N
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic [N-1:0] a,
  input logic [N-1:0] b,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] prod
);
  logic signed [W-1:0] ext_a;
  logic signed [W-1:0] ext_b;
  logic signed [W-1:0] ref_p;

  assign ext_a = W'($signed(a));
  assign ext_b = W'($signed(b));
  assign ref_p = ext_a * ext_b;

  if (REG_OUT) begin : g_reg_chk
    // R1
    product_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> (prod == $past(ref_p)));
    // R3
    accept_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> out_valid);
    // R4
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(prod)));
    // R5
    empty_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> in_ready);
  end else begin : g_comb_chk
    // R1
    product_comb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (prod == ref_p));
    // R6
    pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid == in_valid) && (in_ready == out_ready));
  end
endmodule

bind bw_mult bw_mult_chk #(.N(N), .REG_OUT(REG_OUT)) u_chk (.*);

// File: tb/bw_mult_bench.sv
module bw_mult_bench;
  localparam int CLK_PER = 10;

  logic clk = 1'b0;
  logic rst_n;
  always #(CLK_PER/2) clk = ~clk;

  logic       v5, rdy5, ov5, or5;
  logic [4:0] a5, b5;
  logic [9:0] p5;
  logic       v8, rdy8, ov8, or8;
  logic [7:0] a8, b8;
  logic [15:0] p8;

  bw_mult #(.N(5), .REG_OUT(1'b1)) u_bw_mult (
    .clk(clk), .rst_n(rst_n), .in_valid(v5), .in_ready(rdy5), .a(a5), .b(b5),
    .out_valid(ov5), .out_ready(or5), .prod(p5));

  bw_mult #(.N(8), .REG_OUT(1'b0)) u_bw_mult_w8 (
    .clk(clk), .rst_n(rst_n), .in_valid(v8), .in_ready(rdy8), .a(a8), .b(b8),
    .out_valid(ov8), .out_ready(or8), .prod(p8));

  int checks = 0;
  int fails = 0;
  bit done = 0;
  bit active = 0;
  bit pend5 = 0;
  logic [9:0]  q5_p[$];
  int          q5_t[$];
  logic [15:0] q8_p[$];
  int          q8_t[$];

  function automatic string tagname(int t);
    case (t)
      2: return "R2";
      8: return "R8";
      9: return "R9";
      default: return "R1";
    endcase
  endfunction

  task automatic check(bit ok, string tag, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // R2 min*min, R9 zero, R8 minus one, otherwise R1
  function automatic int tag5(logic [4:0] x, logic [4:0] y);
    if (x == 5'h10 && y == 5'h10) return 2;
    if (x == 0 || y == 0) return 9;
    if (x == 5'h1f || y == 5'h1f) return 8;
    return 1;
  endfunction

  function automatic int tag8(logic [7:0] x, logic [7:0] y);
    if (x == 8'h80 && y == 8'h80) return 2;
    if (x == 0 || y == 0) return 9;
    if (x == 8'hff || y == 8'hff) return 8;
    return 1;
  endfunction

  task automatic drive5(logic [4:0] x, logic [4:0] y);
    bit acc = 0;
    @(negedge clk); #1;
    a5 = x; b5 = y; v5 = 1'b1;
    #1;
    if (pend5) begin
      // R3: previous accepted pair is on the output one cycle later
      check(ov5 == 1'b1, "R3", "out_valid after accept", ov5, 1);
      pend5 = 0;
    end
    while (!acc) begin
      if (rdy5) begin
        acc = 1;
        q5_p.push_back(10'($signed({{5{x[4]}}, x}) * $signed({{5{y[4]}}, y})));
        q5_t.push_back(tag5(x, y));
      end else begin
        @(negedge clk); #2;
      end
    end
    pend5 = 1;
  endtask

  task automatic drive8(logic [7:0] x, logic [7:0] y);
    bit acc = 0;
    @(negedge clk); #1;
    a8 = x; b8 = y; v8 = 1'b1;
    #1;
    while (!acc) begin
      if (rdy8) begin
        acc = 1;
        q8_p.push_back(16'($signed({{8{x[7]}}, x}) * $signed({{8{y[7]}}, y})));
        q8_t.push_back(tag8(x, y));
      end else begin
        @(negedge clk); #2;
      end
    end
  endtask

  // consumer ready patterns
  initial begin
    forever begin
      @(negedge clk); #1;
      if (active) begin
        or5 = ($urandom % 4) != 0;
        or8 = ($urandom % 3) != 0;
      end
    end
  end

  // monitor for the registered instance
  initial begin
    bit stall5 = 0;
    logic [9:0] hold5 = '0;
    forever begin
      @(negedge clk); #3;
      if (active) begin
        if (stall5) begin
          check(ov5 == 1'b1, "R4", "valid held in stall", ov5, 1);
          check(p5 == hold5, "R4", "prod held in stall", p5, hold5);
        end
        check(rdy5 == (!ov5 || or5), "R5", "in_ready", rdy5, !ov5 || or5);
        if (ov5 && or5) begin
          if (q5_p.size() == 0) check(1'b0, "R1", "unexpected output N=5", p5, 0);
          else begin
            logic [9:0] e;
            int t;
            e = q5_p.pop_front();
            t = q5_t.pop_front();
            check(p5 == e, tagname(t), "product N=5", $signed(p5), $signed(e));
          end
        end
        stall5 = ov5 && !or5;
        hold5 = p5;
      end
    end
  end

  // monitor for the pass-through instance
  initial begin
    forever begin
      @(negedge clk); #3;
      if (active) begin
        check(ov8 == v8 && rdy8 == or8, "R6", "handshake pass-through",
              {ov8, rdy8}, {v8, or8});
        if (ov8 && or8) begin
          if (q8_p.size() == 0) check(1'b0, "R6", "unexpected output N=8", p8, 0);
          else begin
            logic [15:0] e;
            int t;
            e = q8_p.pop_front();
            t = q8_t.pop_front();
            check(p8 == e, tagname(t), "product N=8", $signed(p8), $signed(e));
          end
        end
      end
    end
  end

  initial begin
    #(CLK_PER * 150000);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog expired: actual 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    v5 = 0; v8 = 0; or5 = 1; or8 = 1;
    a5 = '0; b5 = '0; a8 = '0; b8 = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #3;
    // R7 reset state
    check(ov5 == 1'b0, "R7", "out_valid after reset", ov5, 0);
    check(rdy5 == 1'b1, "R7", "in_ready after reset", rdy5, 1);
    check(ov8 == 1'b0, "R7", "out_valid after reset N=8", ov8, 0);
    active = 1;

    // every pair for N=5 (R1, R2, R8, R9 by tag)
    for (int i = 0; i < 32; i++)
      for (int j = 0; j < 32; j++)
        drive5(5'(i), 5'(j));
    @(negedge clk); #1; v5 = 1'b0;
    while (q5_p.size() != 0) @(negedge clk);

    // N=8 corners then random pairs
    drive8(8'h80, 8'h80);
    drive8(8'h80, 8'hff);
    drive8(8'hff, 8'h80);
    drive8(8'h00, 8'h80);
    drive8(8'h7f, 8'h7f);
    drive8(8'h7f, 8'h80);
    drive8(8'hff, 8'hff);
    for (int k = 0; k < 1500; k++) drive8(8'($urandom), 8'($urandom));
    @(negedge clk); #1; v8 = 1'b0;
    while (q8_p.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule